// File: doc/BRIEF.md
# Rotating-State Sum and Sum-of-Squares Accumulator

This block collects two running statistics over a stream of signed integer samples: the plain total and the total of squares. It accepts one sample per clock with no back-pressure. The accumulation adder is modelled as a pipeline of `LAT` register stages. To keep that latency out of the feedback path, `LAT` independent partial states circulate around the adder loop. Each sample that reaches the adder is folded into the partial state leaving the pipeline on that cycle. A single counter, shared by all partial states, records how many valid samples were folded in.

Squaring runs in a pipelined stage of depth `MUL_LAT`. The sample and its valid flag are delayed by the same amount, so all three reach the adder loop together. Software reads the statistics by holding `rd_req` for `LAT` consecutive cycles. Each read cycle presents one partial state on the outputs and clears it on the way back into the loop. The first read cycle also presents the sample count and restarts it. The host adds the `LAT` partial totals together. Outside a read, the outputs keep rotating through the live partial states, so the running totals can be watched.

Top module: `rotating_moment_acc`

## Requirements
- R1: After reset, `out_valid`, `out_first`, `out_sum`, `out_sqsum` and `out_count` are all zero.
- R2: Each sample is squared as a signed value. The square reaches the adder loop in the same cycle as its sample and valid flag, `MUL_LAT` cycles after entry.
- R3: Over a read of `LAT` cycles, the `out_sum` values marked valid add up to the signed total of every sample that reached the adder loop, with valid set, since the previous read began.
- R4: The shared count increases only for samples whose valid flag is set. Samples presented with `in_valid` low change neither the count nor any total.
- R5: A read is `rd_req` held high for `LAT` cycles. It produces exactly `LAT` consecutive cycles with `out_valid` set, each carrying a different partial state.
- R6: Over a read, the valid `out_sqsum` values add up to the total of the squares of the same samples counted in R3.
- R7: `out_first` is set only on the first valid cycle of a read. On that cycle `out_count` holds the number of valid samples in the finished epoch. The count then restarts from the samples that arrive during the read.
- R8: A valid sample that reaches the adder loop during a read is added to a freshly cleared state. It is not lost, and it appears in the totals of the following read.
- R9: With no read in progress and no sample in flight, any `LAT` consecutive `out_sum` values add up to the running total of the current epoch.
- R10: `out_valid` in a cycle equals `rd_req` in the previous cycle, so outputs are registered one cycle behind the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | DATA_W | Signed sample |
| rd_req | input | 1 | Read and clear request, held for LAT cycles |
| out_valid | output | 1 | Output carries a partial state being unloaded |
| out_first | output | 1 | First cycle of a read; out_count is fresh |
| out_sum | output | SUM_W | Signed partial total leaving the loop |
| out_sqsum | output | SQACC_W | Partial total of squares leaving the loop |
| out_count | output | CNT_W | Sample count of the finished epoch |

## Verification
The bench first sweeps every one of the 256 sample values through the block and reads the result. A squarer that treated its input as unsigned would show up here as a wrong square total. It then drives random bursts with reads placed at intervals, both with traffic during the read and back-to-back with a one-cycle gap. A design that folded a sample into an uncleared state, or dropped it during a clear, would give a wrong total for the following epoch. A design with a misaligned valid delay would count a sample in the wrong epoch, so both the count and the totals would miss at the epoch boundary. Idle windows check that the rotating outputs sum to the running total, which catches a state that skips or repeats in the rotation.

// File: rtl/rma_pkg.sv
package rma_pkg;
  function automatic int square_width(input int dw);
    return 2 * dw;
  endfunction
endpackage

// File: rtl/rma_square_pipe.sv
module rma_square_pipe #(
  parameter int DATA_W  = 8,
  parameter int MUL_LAT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_v,
  input  logic signed [DATA_W-1:0]   in_x,
  output logic                       al_v,
  output logic signed [DATA_W-1:0]   al_x,
  output logic [2*DATA_W-1:0]        al_sq
);
  localparam int SQ_W = 2 * DATA_W;

  logic                     v_q  [MUL_LAT];
  logic signed [DATA_W-1:0] x_q  [MUL_LAT];
  logic [SQ_W-1:0]          sq_q [MUL_LAT];
  logic signed [SQ_W-1:0]   prod_d;

  always_comb prod_d = in_x * in_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0]  <= 1'b0;
      x_q[0]  <= '0;
      sq_q[0] <= '0;
    end else begin
      v_q[0]  <= in_v;
      x_q[0]  <= in_x;
      sq_q[0] <= prod_d;
    end
  end

  for (genvar s = 1; s < MUL_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s]  <= 1'b0;
        x_q[s]  <= '0;
        sq_q[s] <= '0;
      end else begin
        v_q[s]  <= v_q[s-1];
        x_q[s]  <= x_q[s-1];
        sq_q[s] <= sq_q[s-1];
      end
    end
  end

  assign al_v  = v_q[MUL_LAT-1];
  assign al_x  = x_q[MUL_LAT-1];
  assign al_sq = sq_q[MUL_LAT-1];

  // R2: a square never exceeds the largest magnitude squared
  a_r2_square_range: assert property (@(posedge clk) disable iff (!rst_n)
    al_sq <= SQ_W'((1 << (DATA_W-1)) * (1 << (DATA_W-1))));
endmodule

// File: rtl/rma_add_ring.sv
module rma_add_ring #(
  parameter int W   = 24,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  input  logic         clr,
  output logic [W-1:0] head
);
  logic [W-1:0] st_q [LAT];
  logic [W-1:0] base_d;
  logic [W-1:0] entry_d;

  always_comb begin
    base_d  = clr ? '0 : st_q[LAT-1];
    entry_d = base_d + (add_en ? add_val : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= '0;
    else        st_q[0] <= entry_d;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= st_q[s-1];
    end
  end

  assign head = st_q[LAT-1];

  // R4: with nothing added and no clear, the leaving state re-enters unchanged
  a_r4_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !clr) |=> st_q[0] == $past(head));
  // R8: a cleared state restarts from the sample alone
  a_r8_clear_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && add_en) |=> st_q[0] == $past(add_val));
endmodule

// File: rtl/rma_tally.sv
module rma_tally #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (restart) cnt_d = CNT_W'(inc);
    else         cnt_d = cnt + CNT_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R4: outside a restart the count never moves backwards
  a_r4_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> cnt >= $past(cnt));
endmodule

// File: rtl/rotating_moment_acc.sv
module rotating_moment_acc
  import rma_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LAT        = 3,
  parameter int MUL_LAT    = 2,
  parameter int EPOCH_LOG2 = 16,
  parameter int SUM_W      = DATA_W + EPOCH_LOG2,
  parameter int SQACC_W    = 2 * DATA_W + EPOCH_LOG2,
  parameter int CNT_W      = EPOCH_LOG2 + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [DATA_W-1:0]  in_data,
  input  logic                      rd_req,
  output logic                      out_valid,
  output logic                      out_first,
  output logic signed [SUM_W-1:0]   out_sum,
  output logic [SQACC_W-1:0]        out_sqsum,
  output logic [CNT_W-1:0]          out_count
);
  localparam int SQ_W = square_width(DATA_W);

  logic                     al_v;
  logic signed [DATA_W-1:0] al_x;
  logic [SQ_W-1:0]          al_sq;
  logic [SUM_W-1:0]         sum_ext;
  logic [SQACC_W-1:0]       sq_ext;
  logic [SUM_W-1:0]         head_sum;
  logic [SQACC_W-1:0]       head_sq;
  logic [CNT_W-1:0]         cnt;
  logic                     rd_q;
  logic                     first_d;
  logic [CNT_W-1:0]         count_d;

  rma_square_pipe #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) i_sq (
    .clk(clk), .rst_n(rst_n), .in_v(in_valid), .in_x(in_data),
    .al_v(al_v), .al_x(al_x), .al_sq(al_sq));

  always_comb begin
    sum_ext = {{(SUM_W-DATA_W){al_x[DATA_W-1]}}, al_x};
    sq_ext  = {{(SQACC_W-SQ_W){1'b0}}, al_sq};
    first_d = rd_req & ~rd_q;
    count_d = first_d ? cnt : out_count;
  end

  rma_add_ring #(.W(SUM_W), .LAT(LAT)) i_ring_sum (
    .clk(clk), .rst_n(rst_n), .add_en(al_v), .add_val(sum_ext),
    .clr(rd_req), .head(head_sum));

  rma_add_ring #(.W(SQACC_W), .LAT(LAT)) i_ring_sq (
    .clk(clk), .rst_n(rst_n), .add_en(al_v), .add_val(sq_ext),
    .clr(rd_req), .head(head_sq));

  rma_tally #(.CNT_W(CNT_W)) i_tally (
    .clk(clk), .rst_n(rst_n), .inc(al_v), .restart(first_d), .cnt(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_sum   <= '0;
      out_sqsum <= '0;
      out_count <= '0;
    end else begin
      rd_q      <= rd_req;
      out_valid <= rd_req;
      out_first <= first_d;
      out_sum   <= head_sum;
      out_sqsum <= head_sq;
      out_count <= count_d;
    end
  end

  // R7: the count marker only appears inside a read
  a_r7_first_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  // R10: a request shows as a valid output one cycle later
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> out_valid);
  // R10: no request, no valid output
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !out_valid);
  // R7: a rising request marks the first read cycle
  a_r7_first_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_q) |=> out_first);
  // R7: the published count holds between reads
  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_first |-> $stable(out_count));
endmodule

// File: tb/test_rotating_moment_acc.sv
module test_rotating_moment_acc;
  localparam int DATA_W = 8, LAT = 3, MUL_LAT = 2, EPOCH_LOG2 = 16;
  localparam int SUM_W = DATA_W + EPOCH_LOG2;
  localparam int SQACC_W = 2 * DATA_W + EPOCH_LOG2;
  localparam int CNT_W = EPOCH_LOG2 + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DATA_W-1:0] in_data;
  logic rd_req;
  logic out_valid, out_first;
  logic signed [SUM_W-1:0] out_sum;
  logic [SQACC_W-1:0] out_sqsum;
  logic [CNT_W-1:0] out_count;

  always #2.5 clk = ~clk;

  rotating_moment_acc #(.DATA_W(DATA_W), .LAT(LAT), .MUL_LAT(MUL_LAT),
    .EPOCH_LOG2(EPOCH_LOG2)) i_rotating_moment_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_req(rd_req), .out_valid(out_valid), .out_first(out_first),
    .out_sum(out_sum), .out_sqsum(out_sqsum), .out_count(out_count));

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit     pv [MUL_LAT];
  longint px [MUL_LAT];
  longint accT = 0, accQ = 0, accN = 0;
  longint snapT = 0, snapQ = 0, snapN = 0;
  bit     rd_prev = 0, last_rd = 0, prev_ov = 0;
  longint gotT = 0, gotQ = 0;
  int     nrd = 0;
  longint last_sum = 0;
  string  sum_tag = "R3";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic observe();
    check(out_valid == last_rd, "R10 out_valid vs prior rd_req", out_valid, last_rd);
    if (out_valid) begin
      if (out_first) begin
        check(out_count == snapN, "R7 R4 epoch count", out_count, snapN);
        gotT = 0; gotQ = 0; nrd = 0;
      end
      gotT += longint'(out_sum);
      gotQ += longint'(out_sqsum);
      nrd++;
    end else if (out_first) begin
      check(0, "R7 first outside read", 1, 0);
    end
    if (prev_ov && !out_valid) begin
      check(nrd == LAT, "R5 read length", nrd, LAT);
      check(gotT == snapT, sum_tag, gotT, snapT);
      check(gotQ == snapQ, "R6 R2 square total", gotQ, snapQ);
    end
    prev_ov  = out_valid;
    last_sum = longint'(out_sum);
  endtask

  task automatic step(input bit v, input int x, input bit rd);
    bit     av;
    longint ax;
    in_valid = v; in_data = DATA_W'(x); rd_req = rd;
    av = pv[MUL_LAT-1]; ax = px[MUL_LAT-1];
    for (int i = MUL_LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; px[i] = px[i-1]; end
    pv[0] = v; px[0] = longint'($signed(DATA_W'(x)));
    if (rd && !rd_prev) begin
      snapT = accT; snapQ = accQ; snapN = accN;
      accT = 0; accQ = 0; accN = 0;
    end
    if (av) begin accT += ax; accQ += ax * ax; accN++; end
    rd_prev = rd;
    @(posedge clk);
    @(negedge clk);
    last_rd = rd;
    observe();
  endtask

  task automatic read_window(input bit traffic);
    for (int j = 0; j < LAT; j++)
      step(traffic ? bit'($urandom_range(0, 1)) : 1'b0, int'($urandom_range(0, 255)) - 128, 1'b1);
  endtask

  task automatic idle_view();
    longint s;
    for (int j = 0; j < MUL_LAT + LAT + 2; j++) step(0, 0, 0);
    s = 0;
    for (int j = 0; j < LAT; j++) begin step(0, 0, 0); s += last_sum; end
    check(s == accT, "R9 rotating total", s, accT);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MUL_LAT; i++) begin pv[i] = 0; px[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; rd_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 0 && out_first == 0, "R1 reset flags", out_valid, 0);
    check(out_sum == 0 && out_sqsum == 0, "R1 reset totals", out_sum, 0);
    check(out_count == 0, "R1 reset count", out_count, 0);

    // full sweep of sample values, invalid every fourth cycle
    for (int x = -128; x < 128; x++) step((x & 3) != 0, x, 0);
    idle_view();
    sum_tag = "R3 sweep total";
    read_window(0);
    step(0, 0, 0);

    // empty epoch read
    sum_tag = "R3 empty epoch";
    step(0, 0, 0);
    read_window(0);
    step(0, 0, 0);

    // bursty random traffic, reads with traffic inside
    for (int r = 0; r < 12; r++) begin
      int blen = int'($urandom_range(20, 300));
      for (int i = 0; i < blen; i++) begin
        bit burst = ((i / 7) % 3) != 0;
        step(burst && ($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)) - 128, 0);
      end
      if (r % 3 == 0) idle_view();
      sum_tag = (r == 0) ? "R3 burst total" : "R8 total after read with traffic";
      read_window(1);
    end
    for (int i = 0; i < 40; i++) step(1, int'($urandom_range(0, 255)) - 128, 0);
    // back-to-back reads, one-cycle gap
    sum_tag = "R8 back-to-back first";
    read_window(1);
    step(1, 127, 0);
    sum_tag = "R8 back-to-back second";
    read_window(1);
    step(1, -128, 0);
    idle_view();
    sum_tag = "R8 closing epoch";
    read_window(0);
    step(0, 0, 0);
    step(0, 0, 0);

    done = 1;
    report();
    $finish;
  end
endmodule